// File: doc/BRIEF.md
# Calendar Time-of-Day Counter with Daylight-Saving Adjustment

This block holds a full calendar time (second, minute, hour, weekday, day of month, month and two-digit year) as binary counts. Each pulse on the update strobe advances it by one second. Rollover runs through every field, with correct month lengths and leap-year handling. The host reads all fields as bytes in one of two encodings, plain binary or packed BCD. The hour byte can be shown either as a 0–23 count or as a 12-hour value with a PM flag. A single write port, with a field selector, loads any field. The written byte is interpreted in the encoding that is selected at that moment.

With the daylight-saving enable set, the counter makes the two seasonal jumps by itself. It skips an hour early on the first Sunday of April. It repeats an hour once early on the last Sunday of October. A one-bit internal marker records that the autumn repeat has already happened, so the second pass through the repeated hour continues normally. The control inputs are plain level signals sampled every cycle. There is no stream interface, so there is no back-pressure: a strobe or write presented in a cycle is always taken in that cycle.

Top module: `cal_clock`

## Requirements
- R1: After reset the time is 00:00:00, the weekday is 1, the date is 1, the month is 1 and the year is 0.
- R2: Each cycle with `tick` high and `wr_en` low adds one second. Seconds 59 wrap to 0 and carry into minutes. Minutes 59 wrap to 0 and carry into hours. Hour 23 wraps to 0 and carries into the day. The weekday runs 1..7 and goes from 7 back to 1 at midnight.
- R3: April, June, September and November end after day 30. February ends after day 29 when the year is a multiple of 4, and after day 28 otherwise. Every other month ends after day 31. December rolls into month 1 of the next year, and year 99 is followed by year 0.
- R4: In a cycle with neither `tick` nor `wr_en`, no field changes.
- R5: With `fmt_bin`=1 every output byte is the plain binary count. With `fmt_bin`=0 every output byte is packed BCD, with tens in bits 7:4 and units in bits 3:0.
- R6: With `hr24`=1 the hour byte encodes 0..23. With `hr24`=0, bit 7 of the hour byte is 1 for hours 12..23, and bits 6:0 carry 12,1,2..11 for internal hours 0/12, 1/13 .. 11/23. That value is binary or BCD as `fmt_bin` selects.
- R7: `wr_sel` picks the field to load: 0 second, 1 minute, 2 hour, 3 weekday, 4 date, 5 month, 6 year. The written byte is decoded with the current `fmt_bin` and `hr24` settings, as laid out in R5 and R6.
- R8: A cycle with `wr_en` high ignores `tick`.
- R9: A write is discarded, leaving every field unchanged, in either of two cases: its decoded value lies outside the field's range, or `wr_sel` is 7. The ranges are second and minute 0..59, hour 0..23 (12-hour input 1..12), weekday 1..7, date 1..31, month 1..12 and year 0..99.
- R10: With `dst_en`=1, a strobe at 02:00:00 on a Sunday (weekday 1) in month 4 with date 7 or less moves the time to 03:00:00.
- R11: With `dst_en`=1, a strobe at 01:59:59 on a Sunday in month 10 with date 25 or more moves the time to 01:00:00 the first time. Until the date changes, by rollover or by a host write to the date or month field, the same strobe goes on to 02:00:00.
- R12: With `dst_en`=0, neither seasonal jump happens.
- R13: Sundays outside the date windows of R10 and R11, and non-Sundays inside them, advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance strobe |
| fmt_bin | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enables the seasonal adjustments |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 3 | Field selector for writes |
| wr_data | input | 8 | Write byte in the current format |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| dow_o | output | 8 | Weekday byte |
| date_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |

## Verification
The properties hold on every cycle and cover the following: that every internal count stays inside its legal range; that idle cycles freeze the state; that a second steps by exactly one away from its wrap; that midnight moves the weekday; that the spring jump lands on 03:00:00; that the PM flag and the binary pass-through agree with the internal hour. Some behaviour can only be shown by the bench's scenarios. This includes the month-length table across leap and common years, and the full four-way format mapping of every hour. It also includes the one-time nature of the October repeat and its re-arming on a date write, and the discarding of out-of-range writes.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FIELDS   = 7;
  localparam int BYTE_W   = 8;
  localparam int VAL_W    = 7;
  localparam int YEAR_TOP = 99;
  localparam int LEAP_GAP = 4;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DOW  = 3'd3,
    FLD_DATE = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6
  } field_e;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] mon;
    logic [6:0] year;
  } cal_t;

  function automatic logic [BYTE_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [BYTE_W-1:0] bin_to_bcd(input logic [BYTE_W-1:0] v);
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [BYTE_W-1:0] field_lo(input logic [2:0] f);
    case (f)
      FLD_DOW, FLD_DATE, FLD_MON: return 8'd1;
      default:                    return 8'd0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] field_hi(input logic [2:0] f);
    case (f)
      FLD_SEC, FLD_MIN: return 8'd59;
      FLD_HOUR:         return 8'd23;
      FLD_DOW:          return 8'd7;
      FLD_DATE:         return 8'd31;
      FLD_MON:          return 8'd12;
      FLD_YEAR:         return 8'(YEAR_TOP);
      default:          return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/cal_wr_decode.sv
module cal_wr_decode
  import cal_pkg::*;
(
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              fmt_bin,
  input  logic              hr24,
  output logic              wr_ok,
  output field_e            wr_field,
  output logic [VAL_W-1:0]  wr_val
);
  logic [BYTE_W-1:0] plain;
  logic [BYTE_W-1:0] h12;
  logic [BYTE_W-1:0] decoded;
  logic              legal;

  always_comb begin
    plain   = fmt_bin ? wr_data : bcd_to_bin(wr_data);
    h12     = fmt_bin ? {1'b0, wr_data[6:0]} : bcd_to_bin({1'b0, wr_data[6:0]});
    decoded = plain;
    legal   = 1'b1;
    if (wr_sel == FLD_HOUR && !hr24) begin
      legal   = (h12 >= 8'd1) && (h12 <= 8'd12);
      decoded = ((h12 == 8'd12) ? 8'd0 : h12) + (wr_data[7] ? 8'd12 : 8'd0);
    end
    if (decoded < field_lo(wr_sel) || decoded > field_hi(wr_sel)) legal = 1'b0;
    if (wr_sel == 3'd7) legal = 1'b0;
  end

  assign wr_ok    = wr_en && legal;
  assign wr_field = field_e'(wr_sel);
  assign wr_val   = decoded[VAL_W-1:0];
endmodule

// File: rtl/cal_core.sv
module cal_core
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dst_en,
  input  logic             wr_req,
  input  logic             wr_ok,
  input  field_e           wr_field,
  input  logic [VAL_W-1:0] wr_val,
  output cal_t             cur
);
  cal_t nxt;
  logic fb_done, fb_nxt;
  logic spring_hit, fall_hit, leap;
  logic [4:0] month_len;

  assign leap = (32'(cur.year) % LEAP_GAP) == 0;

  always_comb begin
    case (cur.mon)
      4'd2:                      month_len = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
      default:                   month_len = 5'd31;
    endcase
  end

  assign spring_hit = dst_en && cur.mon == 4'd4 && cur.dow == 3'd1 &&
                      cur.date <= 5'd7 && cur.hour == 5'd2 &&
                      cur.min == 6'd0 && cur.sec == 6'd0;
  assign fall_hit   = dst_en && cur.mon == 4'd10 && cur.dow == 3'd1 &&
                      cur.date >= 5'd25 && cur.hour == 5'd1 &&
                      cur.min == 6'd59 && cur.sec == 6'd59 && !fb_done;

  always_comb begin
    nxt    = cur;
    fb_nxt = fb_done;
    if (wr_req) begin
      if (wr_ok) begin
        case (wr_field)
          FLD_SEC:  nxt.sec  = wr_val[5:0];
          FLD_MIN:  nxt.min  = wr_val[5:0];
          FLD_HOUR: nxt.hour = wr_val[4:0];
          FLD_DOW:  nxt.dow  = wr_val[2:0];
          FLD_DATE: begin nxt.date = wr_val[4:0]; fb_nxt = 1'b0; end
          FLD_MON:  begin nxt.mon  = wr_val[3:0]; fb_nxt = 1'b0; end
          default:  nxt.year = wr_val;
        endcase
      end
    end else if (tick) begin
      if (spring_hit) begin
        nxt.hour = 5'd3;
      end else if (fall_hit) begin
        nxt.hour = 5'd1;
        nxt.min  = 6'd0;
        nxt.sec  = 6'd0;
        fb_nxt   = 1'b1;
      end else if (cur.sec < 6'd59) begin
        nxt.sec = cur.sec + 6'd1;
      end else begin
        nxt.sec = 6'd0;
        if (cur.min < 6'd59) begin
          nxt.min = cur.min + 6'd1;
        end else begin
          nxt.min = 6'd0;
          if (cur.hour < 5'd23) begin
            nxt.hour = cur.hour + 5'd1;
          end else begin
            nxt.hour = 5'd0;
            fb_nxt   = 1'b0;
            nxt.dow  = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
            if (cur.date < month_len) begin
              nxt.date = cur.date + 5'd1;
            end else begin
              nxt.date = 5'd1;
              if (cur.mon < 4'd12) begin
                nxt.mon = cur.mon + 4'd1;
              end else begin
                nxt.mon  = 4'd1;
                nxt.year = (cur.year >= 7'(YEAR_TOP)) ? 7'd0 : cur.year + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, dow: 3'd1,
                   date: 5'd1, mon: 4'd1, year: 7'd0};
      fb_done <= 1'b0;
    end else begin
      cur     <= nxt;
      fb_done <= fb_nxt;
    end
  end
endmodule

// File: rtl/cal_fmt.sv
module cal_fmt
  import cal_pkg::*;
(
  input  cal_t                          cur,
  input  logic                          fmt_bin,
  input  logic                          hr24,
  output logic [FIELDS-1:0][BYTE_W-1:0] bytes_o
);
  logic [FIELDS-1:0][BYTE_W-1:0] raw;

  assign raw[FLD_SEC]  = {2'b0, cur.sec};
  assign raw[FLD_MIN]  = {2'b0, cur.min};
  assign raw[FLD_HOUR] = {3'b0, cur.hour};
  assign raw[FLD_DOW]  = {5'b0, cur.dow};
  assign raw[FLD_DATE] = {3'b0, cur.date};
  assign raw[FLD_MON]  = {4'b0, cur.mon};
  assign raw[FLD_YEAR] = {1'b0, cur.year};

  for (genvar i = 0; i < FIELDS; i++) begin : g_byte
    if (i == int'(FLD_HOUR)) begin : g_hour
      logic              pm;
      logic [BYTE_W-1:0] h12, h12_enc;
      assign pm      = raw[i] >= 8'd12;
      assign h12     = (raw[i] == 8'd0)  ? 8'd12 :
                       (raw[i] > 8'd12)  ? raw[i] - 8'd12 : raw[i];
      assign h12_enc = fmt_bin ? h12 : bin_to_bcd(h12);
      assign bytes_o[i] = hr24 ? (fmt_bin ? raw[i] : bin_to_bcd(raw[i]))
                               : {pm, h12_enc[6:0]};
    end else begin : g_plain
      assign bytes_o[i] = fmt_bin ? raw[i] : bin_to_bcd(raw[i]);
    end
  end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fmt_bin,
  input  logic       hr24,
  input  logic       dst_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  logic                          wr_ok;
  field_e                        wr_field;
  logic [VAL_W-1:0]              wr_val;
  cal_t                          cur;
  logic [FIELDS-1:0][BYTE_W-1:0] bytes;

  cal_wr_decode u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fmt_bin(fmt_bin), .hr24(hr24),
    .wr_ok(wr_ok), .wr_field(wr_field), .wr_val(wr_val)
  );

  cal_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dst_en(dst_en),
    .wr_req(wr_en), .wr_ok(wr_ok), .wr_field(wr_field), .wr_val(wr_val),
    .cur(cur)
  );

  cal_fmt u_fmt (
    .cur(cur), .fmt_bin(fmt_bin), .hr24(hr24), .bytes_o(bytes)
  );

  assign sec_o  = bytes[FLD_SEC];
  assign min_o  = bytes[FLD_MIN];
  assign hour_o = bytes[FLD_HOUR];
  assign dow_o  = bytes[FLD_DOW];
  assign date_o = bytes[FLD_DATE];
  assign mon_o  = bytes[FLD_MON];
  assign year_o = bytes[FLD_YEAR];
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic       dst_en,
  input logic       fmt_bin,
  input logic       hr24,
  input cal_t       cur,
  input logic [7:0] sec_o,
  input logic [7:0] hour_o
);
  AST_RANGE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    cur.sec <= 6'd59 && cur.min <= 6'd59 && cur.hour <= 5'd23); // R2
  AST_RANGE_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    cur.dow >= 3'd1 && cur.dow <= 3'd7 && cur.date >= 5'd1 &&
    cur.mon >= 4'd1 && cur.mon <= 4'd12 && cur.year <= 7'(YEAR_TOP)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(cur)); // R4
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && cur.sec < 6'd59 && cur.min != 6'd0
    |=> cur.sec == $past(cur.sec) + 6'd1); // R2
  AST_MIDNIGHT_DOW: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && cur.hour == 5'd23 && cur.min == 6'd59 && cur.sec == 6'd59
    |=> cur.hour == 5'd0 && cur.dow != $past(cur.dow)); // R2
  AST_SPRING_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && dst_en && cur.mon == 4'd4 && cur.dow == 3'd1 &&
    cur.date <= 5'd7 && cur.hour == 5'd2 && cur.min == 6'd0 && cur.sec == 6'd0
    |=> cur.hour == 5'd3 && cur.min == 6'd0 && cur.sec == 6'd0); // R10
  AST_PM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !hr24 |-> hour_o[7] == (cur.hour >= 5'd12)); // R6
  AST_BIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_bin |-> sec_o == {2'b0, cur.sec}); // R5
endmodule

bind cal_clock cal_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .dst_en(dst_en),
  .fmt_bin(fmt_bin), .hr24(hr24), .cur(cur), .sec_o(sec_o), .hour_o(hour_o)
);

// File: tb/cal_clock_test.sv
module cal_clock_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, fmt_bin = 1'b1, hr24 = 1'b1, dst_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_clock uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_bin(fmt_bin), .hr24(hr24),
    .dst_en(dst_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .mon_o(mon_o), .year_o(year_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hour(input int h, input bit df, input bit hf);
    int h12;
    if (hf) return df ? 8'(h) : bcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return (df ? 8'(h12) : bcd(h12)) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input int yr, input int mo, input int dt, input int dw,
                         input int h, input int m, input int s);
    fmt_bin = 1'b1; hr24 = 1'b1;
    wr(6, 8'(yr)); wr(5, 8'(mo)); wr(4, 8'(dt)); wr(3, 8'(dw));
    wr(2, 8'(h));  wr(1, 8'(m));  wr(0, 8'(s));
  endtask

  task automatic chk_time(input string req, input int h, input int m, input int s);
    fmt_bin = 1'b1; hr24 = 1'b1; #1;
    chk(req, hour_o, 8'(h)); chk(req, min_o, 8'(m)); chk(req, sec_o, 8'(s));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap [7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", sec_o, 8'd0); chk("R1", min_o, 8'd0); chk("R1", hour_o, 8'd0);
    chk("R1", dow_o, 8'd1); chk("R1", date_o, 8'd1); chk("R1", mon_o, 8'd1);
    chk("R1", year_o, 8'd0);

    // R2 continuous ticking over an hour and a bit
    set_all(5, 1, 1, 1, 0, 0, 0);
    @(negedge clk); tick = 1'b1;
    for (int n = 1; n <= 3700; n++) begin
      @(negedge clk);
      chk("R2", sec_o, 8'(n % 60));
      chk("R2", min_o, 8'((n / 60) % 60));
      chk("R2", hour_o, 8'(n / 3600));
    end
    tick = 1'b0;

    // R2 weekday wrap at midnight
    set_all(5, 1, 1, 7, 23, 59, 59);
    step(); #1;
    chk("R2", dow_o, 8'd1); chk("R2", date_o, 8'd2);
    chk_time("R2", 0, 0, 0);

    // R3 month ends across a common and a leap year
    for (int yr = 3; yr <= 4; yr++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_all(yr, mo, mdays(mo, yr) - 1, 2, 23, 59, 59);
        step(); #1;
        chk("R3", date_o, 8'(mdays(mo, yr)));
        chk("R3", mon_o, 8'(mo));
        wr(2, 8'd23); wr(1, 8'd59); wr(0, 8'd59);
        step(); #1;
        chk("R3", date_o, 8'd1);
        chk("R3", mon_o, 8'((mo % 12) + 1));
        chk("R3", year_o, 8'((mo == 12) ? yr + 1 : yr));
      end
    end
    set_all(99, 12, 31, 3, 23, 59, 59);
    step(); #1;
    chk("R3", year_o, 8'd0); chk("R3", mon_o, 8'd1); chk("R3", date_o, 8'd1);

    // R4 idle hold
    set_all(7, 3, 9, 4, 10, 20, 30);
    #1;
    snap[0] = sec_o; snap[1] = min_o; snap[2] = hour_o; snap[3] = dow_o;
    snap[4] = date_o; snap[5] = mon_o; snap[6] = year_o;
    repeat (6) @(negedge clk);
    #1;
    chk("R4", sec_o, snap[0]); chk("R4", min_o, snap[1]); chk("R4", hour_o, snap[2]);
    chk("R4", dow_o, snap[3]); chk("R4", date_o, snap[4]); chk("R4", mon_o, snap[5]);
    chk("R4", year_o, snap[6]);

    // R5 R6 R7 every hour written in each format, read in each format
    for (int h = 0; h < 24; h++) begin
      for (int wf = 0; wf < 4; wf++) begin
        fmt_bin = wf[0]; hr24 = wf[1];
        wr(2, enc_hour(h, wf[0], wf[1]));
        for (int rf = 0; rf < 4; rf++) begin
          fmt_bin = rf[0]; hr24 = rf[1]; #1;
          chk("R6", hour_o, enc_hour(h, rf[0], rf[1]));
        end
      end
    end
    // R5 R7 BCD writes of seconds, minutes and years
    for (int v = 0; v < 60; v++) begin
      fmt_bin = 1'b0; hr24 = 1'b1;
      wr(0, bcd(v)); wr(1, bcd(59 - v));
      #1;
      chk("R5", sec_o, bcd(v)); chk("R5", min_o, bcd(59 - v));
      fmt_bin = 1'b1; #1;
      chk("R7", sec_o, 8'(v)); chk("R7", min_o, 8'(59 - v));
    end
    for (int v = 0; v < 100; v++) begin
      fmt_bin = 1'b0;
      wr(6, bcd(v)); #1;
      chk("R5", year_o, bcd(v));
      fmt_bin = 1'b1; #1;
      chk("R7", year_o, 8'(v));
    end

    // R8 write wins over a simultaneous tick
    set_all(7, 3, 9, 4, 10, 20, 30);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd10;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk_time("R8", 10, 20, 10);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd70;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk_time("R8", 10, 20, 10);

    // R9 illegal writes
    wr(0, 8'd60); wr(1, 8'd99); wr(2, 8'd24); wr(3, 8'd0); wr(3, 8'd8);
    wr(4, 8'd0); wr(4, 8'd32); wr(5, 8'd13); wr(5, 8'd0); wr(6, 8'd100);
    wr(7, 8'd1);
    hr24 = 1'b0; wr(2, 8'd13); wr(2, 8'h80); hr24 = 1'b1;
    fmt_bin = 1'b0; wr(0, 8'h60); fmt_bin = 1'b1;
    chk_time("R9", 10, 20, 10);
    chk("R9", dow_o, 8'd4); chk("R9", date_o, 8'd9);
    chk("R9", mon_o, 8'd3); chk("R9", year_o, 8'd7);

    // R10 spring forward
    dst_en = 1'b1;
    set_all(8, 4, 5, 1, 2, 0, 0);
    step(); chk_time("R10", 3, 0, 0);
    set_all(8, 4, 7, 1, 1, 59, 59);
    step(); step(); chk_time("R10", 3, 0, 0);
    // R13 outside the windows
    set_all(8, 4, 8, 1, 2, 0, 0);
    step(); chk_time("R13", 2, 0, 1);
    set_all(8, 4, 5, 2, 2, 0, 0);
    step(); chk_time("R13", 2, 0, 1);
    set_all(8, 10, 24, 1, 1, 59, 59);
    step(); chk_time("R13", 2, 0, 0);
    set_all(8, 10, 28, 3, 1, 59, 59);
    step(); chk_time("R13", 2, 0, 0);

    // R11 autumn repeat happens once per date
    set_all(8, 10, 26, 1, 1, 59, 59);
    step(); chk_time("R11", 1, 0, 0);
    wr(2, 8'd1); wr(1, 8'd59); wr(0, 8'd59);
    step(); chk_time("R11", 2, 0, 0);
    wr(4, 8'd26); wr(2, 8'd1); wr(1, 8'd59); wr(0, 8'd59);
    step(); chk_time("R11", 1, 0, 0);

    // R12 adjustments disabled
    dst_en = 1'b0;
    set_all(8, 4, 5, 1, 2, 0, 0);
    step(); chk_time("R12", 2, 0, 1);
    set_all(8, 10, 26, 1, 1, 59, 59);
    step(); chk_time("R12", 2, 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule